// File: doc/BRIEF.md
# 64-bit Integer ALU with 32-bit Word Forms

This block is the integer execution unit of a 64-bit RISC-style core. It is purely combinational. It takes two 64-bit operands, an operation code and a word-mode flag, and it returns a 64-bit result in the same cycle. The second operand is either a register value or an immediate that has already been sign-extended, so each register-amount and immediate-amount form of an operation uses the same datapath.

Add, subtract, the logic functions, signed and unsigned set-less-than, and the three shifts all work across the full 64 bits. When the word flag is set, add, subtract and the shifts work only on the low 32 bits. Bit 31 of that 32-bit value is then copied into bits 63..32. The flag has no effect on the logic functions or on set-less-than. No flags are produced, and carries out of the top bit are dropped.

Operation codes on `op_sel`: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 signed set-less-than, 6 unsigned set-less-than, 7 shift left logical, 8 shift right logical, 9 shift right arithmetic. Codes 10 to 15 are unused.

Top module: `alu64_core`

## Requirements
- R1: With op 0 and word_mode low, result equals opnd_a + opnd_b modulo 2^64, and overflow is ignored.
- R2: With op 1 and word_mode low, result equals opnd_a - opnd_b modulo 2^64.
- R3: With op 0 or 1 and word_mode high, the low 32 bits of the sum or difference of the operands' low halves are sign-extended from bit 31. Bits 63..32 of both operands have no effect.
- R4: Ops 2, 3 and 4 return the bitwise AND, OR and XOR of the operands, and word_mode has no effect on them.
- R5: Op 5 (signed) and op 6 (unsigned) return 1 in bit 0 when opnd_a is less than opnd_b, and 0 otherwise. Bits 63..1 are always zero, and word_mode has no effect.
- R6: With ops 7, 8 and 9 and word_mode low, opnd_a is shifted across all 64 bits by opnd_b[5:0]. A right logical shift fills with zeros, and a right arithmetic shift fills with opnd_a[63].
- R7: With ops 7, 8 and 9 and word_mode high, the shift amount is opnd_b[4:0] and only opnd_a[31:0] is shifted. The 32-bit result is sign-extended from its bit 31.
- R8: A word right logical shift fills zeros in from bit 31 before the sign extension. Any nonzero amount therefore gives bits 63..31 all zero.
- R9: A word right arithmetic shift fills with opnd_a[31]. For example, 0x80000000 shifted by 1 gives 0xFFFFFFFFC0000000.
- R10: Op codes 10 to 15 give a result of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand, or a sign-extended immediate; also supplies the shift amount |
| op_sel | input | 4 | Operation code (see above) |
| word_mode | input | 1 | Selects the 32-bit word form of add, subtract and the shifts |
| result | output | 64 | Operation result |

## Verification
Random operands seldom reach the points where the word and full-width paths differ. These are a low half of exactly 0x7FFFFFFF or 0x80000000, shift amounts that set bit 5 while word mode is on, and operands whose upper halves should be ignored. The stimulus therefore draws part of its operands from a pool of edge values and adds random noise to their upper halves. It sweeps every shift amount from 0 to 63 for each shift kind in both modes, and it drives the two named corner cases directly.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

    localparam int unsigned OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLT  = 4'd5,
        OP_SLTU = 4'd6,
        OP_SLL  = 4'd7,
        OP_SRL  = 4'd8,
        OP_SRA  = 4'd9
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RLOG  = 2'd1,
        SH_RARI  = 2'd2
    } shift_kind_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_fn_e;

    typedef enum logic [2:0] {
        SRC_ZERO  = 3'd0,
        SRC_ARITH = 3'd1,
        SRC_LOGIC = 3'd2,
        SRC_SHIFT = 3'd3,
        SRC_LTS   = 3'd4,
        SRC_LTU   = 3'd5
    } res_src_e;

    typedef struct packed {
        logic        subtract;
        logic        word;
        shift_kind_e sh_kind;
        logic_fn_e   lg_fn;
        res_src_e    src;
    } alu_ctrl_t;

endpackage

// File: rtl/alu64_addsub.sv
module alu64_addsub #(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic            sub_i,
    input  logic            word_i,
    output logic [XLEN-1:0] sum_o,
    output logic            lt_s_o,
    output logic            lt_u_o
);

    localparam int unsigned EXT = XLEN - WLEN;

    logic [XLEN-1:0] b_inv_d;
    logic [XLEN:0]   wide_d;
    logic [XLEN-1:0] raw_d;
    logic            carry_d;

    always_comb begin
        b_inv_d = sub_i ? ~b_i : b_i;
        wide_d  = {1'b0, a_i} + {1'b0, b_inv_d} + {{XLEN{1'b0}}, sub_i};
        raw_d   = wide_d[XLEN-1:0];
        carry_d = wide_d[XLEN];
        if (word_i) begin
            sum_o = {{EXT{raw_d[WLEN-1]}}, raw_d[WLEN-1:0]};
        end else begin
            sum_o = raw_d;
        end
        lt_u_o = sub_i & ~carry_d;
        if (a_i[XLEN-1] != b_i[XLEN-1]) begin
            lt_s_o = a_i[XLEN-1];
        end else begin
            lt_s_o = raw_d[XLEN-1];
        end
    end

    always_comb begin
        if (sub_i) begin
            // R5
            signed_cmp_chk: assert (lt_s_o == ($signed(a_i) < $signed(b_i)))
                else $error("signed compare mismatch");
            // R5
            unsigned_cmp_chk: assert (lt_u_o == (a_i < b_i))
                else $error("unsigned compare mismatch");
        end
    end

endmodule

// File: rtl/alu64_logic.sv
module alu64_logic
    import alu64_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic_fn_e       fn_i,
    output logic [XLEN-1:0] res_o
);

    always_comb begin
        unique case (fn_i)
            LG_AND:  res_o = a_i & b_i;
            LG_OR:   res_o = a_i | b_i;
            LG_XOR:  res_o = a_i ^ b_i;
            default: res_o = '0;
        endcase
    end

endmodule

// File: rtl/alu64_shift.sv
module alu64_shift
    import alu64_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input  logic [XLEN-1:0]         a_i,
    input  logic [$clog2(XLEN)-1:0] amt_i,
    input  shift_kind_e             kind_i,
    input  logic                    word_i,
    output logic [XLEN-1:0]         res_o
);

    localparam int unsigned SHW  = $clog2(XLEN);
    localparam int unsigned WSHW = $clog2(WLEN);
    localparam int unsigned EXT  = XLEN - WLEN;

    logic [XLEN-1:0] src_d;
    logic [XLEN-1:0] pre_d;
    logic [SHW-1:0]  amt_d;
    logic            fill_d;
    logic            left_d;
    logic [XLEN-1:0] stage_d [SHW+1];
    logic [XLEN-1:0] out_d;
    logic [XLEN-1:0] post_d;

    always_comb begin
        left_d = (kind_i == SH_LEFT);
        if (word_i) begin
            if (kind_i == SH_RARI) begin
                src_d = {{EXT{a_i[WLEN-1]}}, a_i[WLEN-1:0]};
            end else begin
                src_d = {{EXT{1'b0}}, a_i[WLEN-1:0]};
            end
            amt_d = {{(SHW-WSHW){1'b0}}, amt_i[WSHW-1:0]};
        end else begin
            src_d = a_i;
            amt_d = amt_i;
        end
        fill_d = (kind_i == SH_RARI) & src_d[XLEN-1];
        for (int i = 0; i < XLEN; i++) begin
            pre_d[i] = left_d ? src_d[XLEN-1-i] : src_d[i];
        end
    end

    assign stage_d[0] = pre_d;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int unsigned DIST = 1 << s;
        assign stage_d[s+1] = amt_d[s]
            ? {{DIST{fill_d}}, stage_d[s][XLEN-1:DIST]}
            : stage_d[s];
    end

    always_comb begin
        for (int i = 0; i < XLEN; i++) begin
            post_d[i] = left_d ? stage_d[SHW][XLEN-1-i] : stage_d[SHW][i];
        end
        out_d = post_d;
        if (word_i) begin
            res_o = {{EXT{out_d[WLEN-1]}}, out_d[WLEN-1:0]};
        end else begin
            res_o = out_d;
        end
    end

    always_comb begin
        if (!word_i && kind_i == SH_RLOG) begin
            // R6
            full_srl_chk: assert (res_o == (a_i >> amt_i))
                else $error("full logical right shift mismatch");
        end
        if (word_i && kind_i == SH_RARI) begin
            // R9
            word_sra_sign_chk: assert (res_o[WLEN-1] == a_i[WLEN-1])
                else $error("word arithmetic shift lost sign");
        end
    end

endmodule

// File: rtl/alu64_core.sv
module alu64_core
    import alu64_pkg::*;
#(
    parameter int unsigned XLEN = 64,
    parameter int unsigned WLEN = 32
) (
    input  logic [XLEN-1:0] opnd_a,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [OP_W-1:0] op_sel,
    input  logic            word_mode,
    output logic [XLEN-1:0] result
);

    localparam int unsigned SHW = $clog2(XLEN);

    alu_op_e         op_d;
    alu_ctrl_t       ctrl_d;
    logic [XLEN-1:0] arith_d;
    logic [XLEN-1:0] logic_d;
    logic [XLEN-1:0] shift_d;
    logic            lt_s_d;
    logic            lt_u_d;
    logic [XLEN-1:0] result_d;

    always_comb begin
        op_d            = alu_op_e'(op_sel);
        ctrl_d.subtract = 1'b0;
        ctrl_d.word     = 1'b0;
        ctrl_d.sh_kind  = SH_LEFT;
        ctrl_d.lg_fn    = LG_AND;
        ctrl_d.src      = SRC_ZERO;
        case (op_d)
            OP_ADD: begin
                ctrl_d.src  = SRC_ARITH;
                ctrl_d.word = word_mode;
            end
            OP_SUB: begin
                ctrl_d.src      = SRC_ARITH;
                ctrl_d.subtract = 1'b1;
                ctrl_d.word     = word_mode;
            end
            OP_AND: begin
                ctrl_d.src   = SRC_LOGIC;
                ctrl_d.lg_fn = LG_AND;
            end
            OP_OR: begin
                ctrl_d.src   = SRC_LOGIC;
                ctrl_d.lg_fn = LG_OR;
            end
            OP_XOR: begin
                ctrl_d.src   = SRC_LOGIC;
                ctrl_d.lg_fn = LG_XOR;
            end
            OP_SLT: begin
                ctrl_d.src      = SRC_LTS;
                ctrl_d.subtract = 1'b1;
            end
            OP_SLTU: begin
                ctrl_d.src      = SRC_LTU;
                ctrl_d.subtract = 1'b1;
            end
            OP_SLL: begin
                ctrl_d.src     = SRC_SHIFT;
                ctrl_d.sh_kind = SH_LEFT;
                ctrl_d.word    = word_mode;
            end
            OP_SRL: begin
                ctrl_d.src     = SRC_SHIFT;
                ctrl_d.sh_kind = SH_RLOG;
                ctrl_d.word    = word_mode;
            end
            OP_SRA: begin
                ctrl_d.src     = SRC_SHIFT;
                ctrl_d.sh_kind = SH_RARI;
                ctrl_d.word    = word_mode;
            end
            default: ctrl_d.src = SRC_ZERO;
        endcase
    end

    alu64_addsub #(
        .XLEN (XLEN),
        .WLEN (WLEN)
    ) addsub_i (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .sub_i  (ctrl_d.subtract),
        .word_i (ctrl_d.word),
        .sum_o  (arith_d),
        .lt_s_o (lt_s_d),
        .lt_u_o (lt_u_d)
    );

    alu64_logic #(
        .XLEN (XLEN)
    ) logic_i (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .fn_i  (ctrl_d.lg_fn),
        .res_o (logic_d)
    );

    alu64_shift #(
        .XLEN (XLEN),
        .WLEN (WLEN)
    ) shift_i (
        .a_i    (opnd_a),
        .amt_i  (opnd_b[SHW-1:0]),
        .kind_i (ctrl_d.sh_kind),
        .word_i (ctrl_d.word),
        .res_o  (shift_d)
    );

    always_comb begin
        unique case (ctrl_d.src)
            SRC_ARITH: result_d = arith_d;
            SRC_LOGIC: result_d = logic_d;
            SRC_SHIFT: result_d = shift_d;
            SRC_LTS:   result_d = {{(XLEN-1){1'b0}}, lt_s_d};
            SRC_LTU:   result_d = {{(XLEN-1){1'b0}}, lt_u_d};
            default:   result_d = '0;
        endcase
    end

    assign result = result_d;

    always_comb begin
        if (op_d == OP_ADD && !word_mode) begin
            // R1
            full_add_chk: assert (result - opnd_b == opnd_a)
                else $error("full add mismatch");
        end
        if (op_d == OP_SUB && !word_mode) begin
            // R2
            full_sub_chk: assert (result + opnd_b == opnd_a)
                else $error("full subtract mismatch");
        end
        if ((op_d == OP_ADD || op_d == OP_SUB) && word_mode) begin
            // R3
            word_arith_ext_chk: assert (result[XLEN-1:WLEN-1] == '0
                                        || result[XLEN-1:WLEN-1] == '1)
                else $error("word add/sub not sign-extended");
        end
        if (op_d == OP_XOR) begin
            // R4
            xor_fn_chk: assert ((result ^ opnd_a) == opnd_b)
                else $error("xor mismatch");
        end
        if (op_d == OP_SLT || op_d == OP_SLTU) begin
            // R5
            slt_upper_chk: assert (result[XLEN-1:1] == '0)
                else $error("set-less-than upper bits nonzero");
        end
        if (op_d == OP_SLL && !word_mode) begin
            // R6
            full_sll_chk: assert (result == (opnd_a << opnd_b[SHW-1:0]))
                else $error("full left shift mismatch");
        end
        if ((op_d == OP_SLL || op_d == OP_SRL || op_d == OP_SRA) && word_mode) begin
            // R7
            word_shift_ext_chk: assert (result[XLEN-1:WLEN-1] == '0
                                        || result[XLEN-1:WLEN-1] == '1)
                else $error("word shift not sign-extended");
        end
        if (op_d == OP_SRL && word_mode && opnd_b[$clog2(WLEN)-1:0] != '0) begin
            // R8
            word_srl_zero_chk: assert (result[XLEN-1:WLEN-1] == '0)
                else $error("word logical right shift not zero-filled");
        end
        if (op_sel > OP_SRA) begin
            // R10
            unused_op_chk: assert (result == '0)
                else $error("unused op gave nonzero result");
        end
    end

endmodule

// File: tb/alu64_core_tb_top.sv
module alu64_core_tb_top;

    localparam int unsigned XLEN = 64;
    localparam int unsigned WLEN = 32;

    logic            clk;
    logic            rst_n;
    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] opnd_b;
    logic [3:0]      op_sel;
    logic            word_mode;
    logic [XLEN-1:0] result;

    int unsigned n_tests;
    int unsigned n_fail;
    bit          done;

    alu64_core #(
        .XLEN (XLEN),
        .WLEN (WLEN)
    ) dut_i (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .op_sel    (op_sel),
        .word_mode (word_mode),
        .result    (result)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [63:0] sx32(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                          input logic [3:0] op, input logic w);
        logic [31:0] t;
        case (op)
            4'd0: begin t = a[31:0] + b[31:0]; return w ? sx32(t) : a + b; end
            4'd1: begin t = a[31:0] - b[31:0]; return w ? sx32(t) : a - b; end
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return {63'd0, $signed(a) < $signed(b)};
            4'd6: return {63'd0, a < b};
            4'd7: begin t = a[31:0] << b[4:0]; return w ? sx32(t) : a << b[5:0]; end
            4'd8: begin t = a[31:0] >> b[4:0]; return w ? sx32(t) : a >> b[5:0]; end
            4'd9: begin
                t = 32'($signed(a[31:0]) >>> b[4:0]);
                return w ? sx32(t) : 64'($signed(a) >>> b[5:0]);
            end
            default: return 64'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] op, input logic w);
        case (op)
            4'd0: return w ? "R3" : "R1";
            4'd1: return w ? "R3" : "R2";
            4'd2, 4'd3, 4'd4: return "R4";
            4'd5, 4'd6: return "R5";
            4'd7: return w ? "R7" : "R6";
            4'd8: return w ? "R8" : "R6";
            4'd9: return w ? "R9" : "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input logic [63:0] a, input logic [63:0] b,
                         input logic [3:0] op, input logic w,
                         input logic [63:0] exp, input string req);
        @(negedge clk);
        opnd_a    = a;
        opnd_b    = b;
        op_sel    = op;
        word_mode = w;
        #1;
        n_tests++;
        if (result !== exp) begin
            n_fail++;
            $display("FAIL %s op=%0d w=%0d a=%h b=%h actual=%h expected=%h",
                     req, op, w, a, b, result, exp);
        end
    endtask

    task automatic run_model(input logic [63:0] a, input logic [63:0] b,
                             input logic [3:0] op, input logic w);
        check(a, b, op, w, model(a, b, op, w), req_of(op, w));
    endtask

    function automatic logic [63:0] pick(input int unsigned k);
        logic [63:0] noise;
        noise = {$urandom(), $urandom()};
        case (k % 10)
            0: return 64'h0;
            1: return '1;
            2: return {noise[63:32], 32'h7FFF_FFFF};
            3: return {noise[63:32], 32'h8000_0000};
            4: return 64'h8000_0000_0000_0000;
            5: return 64'h7FFF_FFFF_FFFF_FFFF;
            6: return {noise[63:32], 32'hFFFF_FFFF};
            7: return 64'd1;
            default: return noise;
        endcase
    endfunction

    initial begin
        n_tests   = 0;
        n_fail    = 0;
        done      = 1'b0;
        rst_n     = 1'b0;
        opnd_a    = '0;
        opnd_b    = '0;
        op_sel    = '0;
        word_mode = 1'b0;
        repeat (4) @(posedge clk);
        rst_n = 1'b1;

        // R1 idle state: zero operands add to zero
        check(64'd0, 64'd0, 4'd0, 1'b0, 64'd0, "R1");
        // R1 wraparound
        check('1, 64'd1, 4'd0, 1'b0, 64'd0, "R1");
        // R3 word overflow corner
        check(64'h0000_0000_7FFF_FFFF, 64'd1, 4'd0, 1'b1, 64'hFFFF_FFFF_8000_0000, "R3");
        check(64'h0000_0000_7FFF_FFFF, 64'd1, 4'd0, 1'b0, 64'h0000_0000_8000_0000, "R1");
        // R3 upper halves ignored
        check(64'hDEAD_BEEF_0000_0005, 64'h1234_5678_0000_0007, 4'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE, "R3");
        // R2 full subtract borrow
        check(64'd0, 64'd1, 4'd1, 1'b0, '1, "R2");
        // R9 word arithmetic shift corner
        check(64'h0000_0000_8000_0000, 64'd1, 4'd9, 1'b1, 64'hFFFF_FFFF_C000_0000, "R9");
        // R6 same operand, full width
        check(64'h0000_0000_8000_0000, 64'd1, 4'd9, 1'b0, 64'h0000_0000_4000_0000, "R6");
        // R8 zero amount keeps sign, nonzero clears it
        check(64'h0000_0000_8000_0000, 64'd0, 4'd8, 1'b1, 64'hFFFF_FFFF_8000_0000, "R8");
        check(64'h0000_0000_8000_0000, 64'd1, 4'd8, 1'b1, 64'h0000_0000_4000_0000, "R8");
        // R7 bit 5 of amount ignored in word mode
        check(64'd1, 64'd33, 4'd7, 1'b1, 64'd2, "R7");
        check(64'd1, 64'd33, 4'd7, 1'b0, 64'h0000_0002_0000_0000, "R6");
        // R5 signed vs unsigned
        check(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 4'd5, 1'b1, 64'd1, "R5");
        check(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 4'd6, 1'b0, 64'd0, "R5");
        // R4 word flag ignored by logic
        check(64'hF0F0_0000_FFFF_0000, 64'hFF00_FF00_0F0F_0F0F, 4'd2, 1'b1, 64'hF000_0000_0F0F_0000, "R4");
        // R10 unused codes
        for (int op = 10; op < 16; op++) begin
            check('1, '1, 4'(op), 1'b0, 64'd0, "R10");
            check('1, '1, 4'(op), 1'b1, 64'd0, "R10");
        end

        // R6 R7 R8 R9 sweep all amounts for every shift kind and mode
        for (int op = 7; op < 10; op++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 64; s++) begin
                    for (int p = 0; p < 4; p++) begin
                        run_model(pick(p + 2), {$urandom(), 26'($urandom()), 6'(s)},
                                  4'(op), w[0]);
                    end
                end
            end
        end

        // all ops, both modes, mixed edge and random operands
        for (int op = 0; op < 16; op++) begin
            for (int w = 0; w < 2; w++) begin
                for (int n = 0; n < 300; n++) begin
                    run_model(pick(n), pick(n / 10 + $urandom_range(0, 9)), 4'(op), w[0]);
                end
            end
        end

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule